// File: doc/BRIEF.md
# Pipelined Synchronous Static Memory with Byte-Lane Write Control

This block is a behavioural synchronous static memory whose inputs and outputs both pass through registers. Each word holds four 9-bit lanes. A lane is eight data bits plus one parity bit. A three-input select decoder decides whether a clock edge carries an access. A write resolver turns a global write strobe, a lane-write gate and four per-lane strobes into a lane mask. An external burst generator supplies the address.

Read data leaves through an output register. The read-data bus has a drive flag that models the pad driver. When the flag is low, the bus reads as zero and stands for high impedance. An output-enable input acts on the flag directly and does not wait for a clock edge. A sleep input freezes every register and the array, and the stored contents are kept.

Top module: `pssram_core`

## Requirements
- R1: An edge carries an access only when `cs_en_n_i` is 0, `cs_hi_i` is 1 and `cs_lo_n_i` is 0. On any other combination nothing is written, and that access does not drive the bus.
- R2: When `gwr_n_i` is 0 on a selected edge, all 36 bits of the word are written. The values of `bgate_n_i` and `ben_n_i` make no difference.
- R3: When `gwr_n_i` is 1 and `bgate_n_i` is 1, the per-lane strobes are blocked. The edge is then a read, and the memory is not changed.
- R4: When `gwr_n_i` is 1 and `bgate_n_i` is 0, each lane b with `ben_n_i[b]` = 0 is written. Lane b covers data bits 8b+7..8b and parity bit 32+b. All other bits keep their old value.
- R5: Any access that writes at least one lane leaves `rdata_vld_o` at 0 during the cycle in which read data for that access would appear.
- R6: A selected read registered on edge N puts the word on `rdata_o` after edge N+1. Reads can be issued back to back. A read issued on the cycle right after a write to the same address returns the new data.
- R7: `oe_n_i` = 1 forces `rdata_vld_o` to 0 and `rdata_o` to zero with no clock edge. When `oe_n_i` = 0, the registered drive state is shown on the bus.
- R8: While `sleep_i` = 1, no register and no memory location changes. Accesses presented during sleep are lost, and the output keeps its last value.
- R9: After reset, `rdata_vld_o` is 0.
- R10: A deselected edge turns the bus off one cycle later, at the same point where read data would have appeared. Deselect therefore takes a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset of the pipeline registers |
| sleep_i | input | 1 | High freezes all state |
| cs_en_n_i | input | 1 | Active-low chip enable |
| cs_hi_i | input | 1 | Active-high select |
| cs_lo_n_i | input | 1 | Active-low select |
| addr_i | input | AW | Word address from the burst generator |
| gwr_n_i | input | 1 | Active-low global write of all lanes |
| bgate_n_i | input | 1 | Active-low gate for the per-lane strobes |
| ben_n_i | input | 4 | Active-low per-lane write strobes |
| wdata_i | input | 36 | Write data; bits 31:0 data, 35:32 lane parity |
| oe_n_i | input | 1 | Active-low output enable, no clock involved |
| rdata_o | output | 36 | Read data, zero when not driven |
| rdata_vld_o | output | 1 | 1 = bus driven, 0 = high impedance |

## Verification
An access is presented at a falling edge and is registered on the next rising edge. Its read result or its bus-off state becomes visible after the rising edge that follows. The bench therefore samples two falling edges after it drives an access, before it changes any input, and in a pipelined sweep it samples the read that was issued two cycles earlier. Output-enable checks wait one time unit after the toggle, with no edge in between. Sleep checks sample after several frozen edges and expect the last output unchanged.

// File: rtl/pssram_pkg.sv
package pssram_pkg;
    localparam int LANES     = 4;
    localparam int DATA_BITS = 8;
    localparam int LANE_W    = DATA_BITS + 1;
    localparam int WORD_W    = LANES * LANE_W;
    localparam int PAR_BASE  = LANES * DATA_BITS;

    typedef logic [LANES-1:0]  lane_mask_t;
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/pssram_wdec.sv
module pssram_wdec
    import pssram_pkg::*;
(
    input  logic       cs_en_n,
    input  logic       cs_hi,
    input  logic       cs_lo_n,
    input  logic       gwr_n,
    input  logic       bgate_n,
    input  lane_mask_t ben_n,
    output logic       sel,
    output lane_mask_t wmask
);
    always_comb begin
        sel   = !cs_en_n && cs_hi && !cs_lo_n;
        wmask = '0;
        if (sel) begin
            if (!gwr_n) begin
                wmask = '1;
            end else if (!bgate_n) begin
                for (int b = 0; b < LANES; b++) begin
                    wmask[b] = !ben_n[b];
                end
            end
        end
    end
endmodule

// File: rtl/pssram_array.sv
module pssram_array
    import pssram_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  lane_mask_t    wmask,
    input  logic [AW-1:0] waddr,
    input  word_t         wdata,
    input  logic [AW-1:0] raddr,
    output word_t         rdata
);
    for (genvar b = 0; b < LANES; b++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];
        logic [LANE_W-1:0] lane_wr;
        logic [LANE_W-1:0] lane_rd;

        assign lane_wr = {wdata[PAR_BASE+b], wdata[b*DATA_BITS +: DATA_BITS]};
        assign lane_rd = lane_mem[raddr];

        always_ff @(posedge clk) begin
            if (wr_en && wmask[b]) begin
                lane_mem[waddr] <= lane_wr;
            end
        end

        assign rdata[b*DATA_BITS +: DATA_BITS] = lane_rd[DATA_BITS-1:0];
        assign rdata[PAR_BASE+b]               = lane_rd[DATA_BITS];
    end
endmodule

// File: rtl/pssram_core.sv
module pssram_core
    import pssram_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sleep_i,
    input  logic                 cs_en_n_i,
    input  logic                 cs_hi_i,
    input  logic                 cs_lo_n_i,
    input  logic [AW-1:0]        addr_i,
    input  logic                 gwr_n_i,
    input  logic                 bgate_n_i,
    input  logic [LANES-1:0]     ben_n_i,
    input  logic [WORD_W-1:0]    wdata_i,
    input  logic                 oe_n_i,
    output logic [WORD_W-1:0]    rdata_o,
    output logic                 rdata_vld_o
);
    typedef struct packed {
        logic          sel;
        lane_mask_t    wmask;
        logic [AW-1:0] addr;
        word_t         wdata;
        logic          drv;
        word_t         dout;
    } state_t;

    state_t     st_d, st_q;
    logic       sel_now;
    lane_mask_t wmask_now;
    logic       mem_we;
    word_t      rd_word;
    lane_mask_t wmask_q;
    word_t      dout_q;

    pssram_wdec u_wdec (
        .cs_en_n (cs_en_n_i),
        .cs_hi   (cs_hi_i),
        .cs_lo_n (cs_lo_n_i),
        .gwr_n   (gwr_n_i),
        .bgate_n (bgate_n_i),
        .ben_n   (ben_n_i),
        .sel     (sel_now),
        .wmask   (wmask_now)
    );

    assign mem_we = !sleep_i && st_q.sel && (st_q.wmask != '0);

    pssram_array #(.DEPTH(DEPTH), .AW(AW)) u_array (
        .clk   (clk),
        .wr_en (mem_we),
        .wmask (st_q.wmask),
        .waddr (st_q.addr),
        .wdata (st_q.wdata),
        .raddr (st_q.addr),
        .rdata (rd_word)
    );

    always_comb begin
        st_d = st_q;
        if (!sleep_i) begin
            st_d.sel   = sel_now;
            st_d.wmask = wmask_now;
            st_d.addr  = addr_i;
            st_d.wdata = wdata_i;
            st_d.drv   = st_q.sel && (st_q.wmask == '0);
            st_d.dout  = rd_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_vld_o = st_q.drv && !oe_n_i;
    assign rdata_o     = rdata_vld_o ? st_q.dout : '0;

    assign wmask_q = st_q.wmask;
    assign dout_q  = st_q.dout;
endmodule

// File: rtl/pssram_core_chk.sv
module pssram_core_chk
    import pssram_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             sleep_i,
    input logic             cs_en_n_i,
    input logic             cs_hi_i,
    input logic             cs_lo_n_i,
    input logic             gwr_n_i,
    input logic             bgate_n_i,
    input logic             oe_n_i,
    input logic [WORD_W-1:0] rdata_o,
    input logic             rdata_vld_o,
    input lane_mask_t       wmask_q,
    input word_t            dout_q
);
    logic sel_in;
    assign sel_in = !cs_en_n_i && cs_hi_i && !cs_lo_n_i;

    assert_full_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_i && sel_in && !gwr_n_i) |=> (wmask_q == 4'hF));

    assert_gate_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_i && gwr_n_i && bgate_n_i) |=> (wmask_q == 4'h0));

    assert_desel_nowrite_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_i && !sel_in) |=> (wmask_q == 4'h0));

    assert_write_blanks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_i && (wmask_q != 4'h0)) |=> !rdata_vld_o);

    assert_read_drives_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_i && sel_in && gwr_n_i && bgate_n_i) ##1 !sleep_i |=> (oe_n_i || rdata_vld_o));

    assert_desel_hiz_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_i && !sel_in) ##1 !sleep_i |=> !rdata_vld_o);

    assert_oe_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n_i |-> (!rdata_vld_o && rdata_o == '0));

    assert_sleep_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |=> $stable(dout_q));
endmodule

bind pssram_core pssram_core_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep_i     (sleep_i),
    .cs_en_n_i   (cs_en_n_i),
    .cs_hi_i     (cs_hi_i),
    .cs_lo_n_i   (cs_lo_n_i),
    .gwr_n_i     (gwr_n_i),
    .bgate_n_i   (bgate_n_i),
    .oe_n_i      (oe_n_i),
    .rdata_o     (rdata_o),
    .rdata_vld_o (rdata_vld_o),
    .wmask_q     (wmask_q),
    .dout_q      (dout_q)
);

// File: tb/pssram_core_tb_top.sv
module pssram_core_tb_top;
    localparam int DEPTH = 64;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sleep_i = 1'b0;
    logic          cs_en_n_i = 1'b1;
    logic          cs_hi_i = 1'b1;
    logic          cs_lo_n_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic          gwr_n_i = 1'b1;
    logic          bgate_n_i = 1'b1;
    logic [3:0]    ben_n_i = 4'hF;
    logic [35:0]   wdata_i = '0;
    logic          oe_n_i = 1'b0;
    logic [35:0]   rdata_o;
    logic          rdata_vld_o;

    int n_chk = 0;
    int n_err = 0;
    logic [35:0] ref_mem [DEPTH];

    always #10 clk = ~clk;

    pssram_core #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i),
        .cs_en_n_i(cs_en_n_i), .cs_hi_i(cs_hi_i), .cs_lo_n_i(cs_lo_n_i),
        .addr_i(addr_i), .gwr_n_i(gwr_n_i), .bgate_n_i(bgate_n_i),
        .ben_n_i(ben_n_i), .wdata_i(wdata_i), .oe_n_i(oe_n_i),
        .rdata_o(rdata_o), .rdata_vld_o(rdata_vld_o)
    );

    function automatic logic [35:0] pat(int a, int s);
        logic [31:0] x;
        x = 32'h9E3779B9 * 32'(a + 1) + 32'h01000193 * 32'(s + 3);
        return {4'(a * 5 + s), x};
    endfunction

    // expected lane merge: lane b = bits 8b+7..8b and bit 32+b
    function automatic logic [35:0] merge(logic [35:0] old, logic [35:0] nw,
                                          logic gw_n, logic gate_n, logic [3:0] bw_n);
        logic [35:0] r;
        r = old;
        for (int b = 0; b < 4; b++) begin
            if (!gw_n || (!gate_n && !bw_n[b])) begin
                r[b*8 +: 8] = nw[b*8 +: 8];
                r[32+b]     = nw[32+b];
            end
        end
        return r;
    endfunction

    task automatic drive(logic en_n, logic hi, logic lo_n, logic gw_n, logic gate_n,
                         logic [3:0] bw_n, logic [AW-1:0] a, logic [35:0] d);
        cs_en_n_i = en_n; cs_hi_i = hi; cs_lo_n_i = lo_n;
        gwr_n_i = gw_n; bgate_n_i = gate_n; ben_n_i = bw_n;
        addr_i = a; wdata_i = d;
    endtask

    task automatic idle();
        drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'hF, '0, '0);
    endtask

    task automatic rd(logic [AW-1:0] a);
        drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'hF, a, '0);
    endtask

    // present one access, then idle; return at the sampling point
    task automatic settle();
        @(negedge clk); idle();
        @(negedge clk);
    endtask

    task automatic chk(string req, logic vld_exp, logic [35:0] exp);
        n_chk++;
        if (rdata_vld_o !== vld_exp || (vld_exp && rdata_o !== exp) ||
            (!vld_exp && rdata_o !== 36'h0)) begin
            n_err++;
            $display("FAIL %s: vld=%0b data=%h expected vld=%0b data=%h",
                     req, rdata_vld_o, rdata_o, vld_exp, vld_exp ? exp : 36'h0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R9 reset", 1'b0, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: global write fills every word regardless of the lane controls
        for (int a = 0; a < DEPTH; a++) begin
            drive(1'b0, 1'b1, 1'b0, 1'b0, 1'(a & 1), 4'(a), AW'(a), pat(a, 0));
            ref_mem[a] = pat(a, 0);
            settle();
            chk("R5 write blanks", 1'b0, '0);
        end

        // R6 / R2: pipelined back-to-back read sweep
        for (int i = 0; i < DEPTH + 2; i++) begin
            if (i >= 2) chk("R2/R6 pipelined read", 1'b1, ref_mem[i-2]);
            if (i < DEPTH) rd(AW'(i)); else idle();
            @(negedge clk);
        end

        // R4: every lane strobe combination with the gate open
        for (int m = 0; m < 16; m++) begin
            drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'(m), AW'(m), pat(m, 7));
            ref_mem[m] = merge(ref_mem[m], pat(m, 7), 1'b1, 1'b0, 4'(m));
            settle();
            chk("R5 lane write blanks", (m == 15), ref_mem[m]);
            rd(AW'(m)); settle();
            chk("R4 lane merge", 1'b1, ref_mem[m]);
        end

        // R3: gate closed blocks every strobe combination
        for (int m = 0; m < 16; m++) begin
            drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'(m), AW'(16 + m), pat(m, 9));
            settle();
            chk("R3 blocked is read", 1'b1, ref_mem[16 + m]);
        end

        // R1 / R10: every non-selecting combination
        for (int c = 0; c < 8; c++) begin
            if (c == 3'b010) continue;
            drive(1'(c >> 2), 1'(c >> 1), 1'(c), 1'b0, 1'b1, 4'hF, AW'(32 + c), pat(c, 11));
            settle();
            chk("R1 deselected write", 1'b0, '0);
            drive(1'(c >> 2), 1'(c >> 1), 1'(c), 1'b1, 1'b1, 4'hF, AW'(32 + c), '0);
            settle();
            chk("R10 deselected read off", 1'b0, '0);
            rd(AW'(32 + c)); settle();
            chk("R1 memory unchanged", 1'b1, ref_mem[32 + c]);
        end

        // R6: read on the cycle right after a write to the same address
        drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, AW'(40), pat(40, 21));
        ref_mem[40] = pat(40, 21);
        @(negedge clk); rd(AW'(40));
        @(negedge clk); idle();
        chk("R5 write before read", 1'b0, '0);
        @(negedge clk);
        chk("R6 read after write", 1'b1, ref_mem[40]);

        // R7: output enable acts without a clock edge
        rd(AW'(41)); settle();
        chk("R7 oe low drives", 1'b1, ref_mem[41]);
        oe_n_i = 1'b1; #1;
        chk("R7 oe high off", 1'b0, '0);
        oe_n_i = 1'b0; #1;
        chk("R7 oe low again", 1'b1, ref_mem[41]);

        // R8: sleep freezes output and memory
        @(negedge clk);
        rd(AW'(42)); settle();
        chk("R8 before sleep", 1'b1, ref_mem[42]);
        sleep_i = 1'b1;
        drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, AW'(43), pat(43, 99));
        repeat (3) @(negedge clk);
        chk("R8 output held", 1'b1, ref_mem[42]);
        idle();
        sleep_i = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R10 off after wake", 1'b0, '0);
        rd(AW'(43)); settle();
        chk("R8 contents kept", 1'b1, ref_mem[43]);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule